// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two W-bit two's-complement numbers and returns their 2W-bit two's-complement product. It takes one multiplier bit per clock, least significant bit first. For each bit it adds one partial product into a single accumulator register, so the datapath needs only one 2W-bit adder.

Each partial product is the multiplicand sign-extended to 2W bits and shifted to the weight of the current multiplier bit. A multiplier bit of 0 contributes zero. The multiplier's top bit carries a weight of -2^(W-1), so its partial product is negated before it is added. Any carry out of the 2W-bit addition is dropped.

A caller pulses `start_i` with both operands while the unit is idle. `busy_o` stays high while accumulation runs. `done_o` pulses once when the product is final, and the product then stays on `product_o` until the next run is accepted.

Top module: `signed_seq_mult`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o` and `product_o` are all zero.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is low captures both operands. `busy_o` is high from that edge onward.
- R3: If a start is accepted at edge k, `busy_o` stays high through edge k+W-1 and falls at edge k+W. `done_o` is high for exactly the one cycle after edge k+W.
- R4: While `done_o` is high, `product_o` equals the signed product of the captured operands as a 2W-bit two's-complement value. Example for W=4: multiplicand 4'b1011 (-5) times multiplier 4'b1101 (-3) gives 8'b00001111 (+15).
- R5: The top multiplier bit has weight -2^(W-1), and the most negative operand value is exact. For W=4: 4'b1000 × 4'b1000 gives 8'b01000000 (+64), and 4'b1000 × 4'b0111 gives 8'b11001000 (-56).
- R6: A `start_i` pulse while `busy_o` is high has no effect. The operands applied with it do not change the result, and `done_o` keeps its original timing.
- R7: After `done_o`, `product_o` holds its value until the next accepted start, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication, sampled when idle |
| mcand_i | input | W | Multiplicand, two's complement |
| mplier_i | input | W | Multiplier, two's complement |
| busy_o | output | 1 | Accumulation in progress |
| done_o | output | 1 | One-cycle pulse: product is final |
| product_o | output | 2W | Accumulated product, two's complement |

## Verification
The assertions assume that operand ports matter only at the edge where a start is accepted. They also assume that `start_i` may be high at any time, including while the unit is busy.

The bench drives every operand pair once for W=4, holding `start_i` high for exactly one idle cycle. In some runs it raises `start_i` again in mid-run with different operands, to exercise the case where a start must be ignored. After a run it changes the operand inputs while idle, so the checks on the held product see the same kind of traffic the assertions allow.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Result width for a given operand width.
  function automatic int prod_width(input int w);
    return 2 * w;
  endfunction

  // Width of the multiplier bit index.
  function automatic int idx_width(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int W  = 4,
  parameter int CW = smul_pkg::idx_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] idx_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic last;

  assign accept_o = start_i && !busy_o;
  assign last     = busy_o && (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
      end else if (busy_o) begin
        if (last) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && (idx_o == '0));

  // R6
  busy_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> busy_o && (idx_o == $past(idx_o) + 1'b1));

  // R3
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> done_o && !busy_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/smul_pp_gen.sv
module smul_pp_gen #(
  parameter int W  = 4,
  parameter int CW = smul_pkg::idx_width(W),
  parameter int P  = smul_pkg::prod_width(W)
) (
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  input  logic [CW-1:0] idx_i,
  output logic [P-1:0]  pp_o
);
  logic [P-1:0] mc_ext;
  logic [P-1:0] cand [W];

  assign mc_ext = P'($signed(mcand_i));

  for (genvar g = 0; g < W; g++) begin : g_pp
    logic [P-1:0] shifted;
    assign shifted = mc_ext << g;
    if (g == W - 1) begin : g_neg
      // sign bit weighs -2^(W-1)
      assign cand[g] = mplier_i[g] ? (~shifted + 1'b1) : '0;
    end else begin : g_pos
      assign cand[g] = mplier_i[g] ? shifted : '0;
    end
  end

  always_comb begin
    pp_o = '0;
    for (int i = 0; i < W; i++) begin
      if (idx_i == CW'(i)) pp_o = cand[i];
    end
  end
endmodule

// File: rtl/smul_acc.sv
module smul_acc #(
  parameter int P = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [P-1:0] addend_i,
  output logic [P-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o + addend_i;  // carry out dropped
  end

  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_o));
endmodule

// File: rtl/signed_seq_mult.sv
module signed_seq_mult #(
  parameter int W = 4,
  localparam int P  = smul_pkg::prod_width(W),
  localparam int CW = smul_pkg::idx_width(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [P-1:0] product_o
);
  logic          accept;
  logic [CW-1:0] idx;
  logic [W-1:0]  mcand_q, mplier_q;
  logic [P-1:0]  pp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (accept) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
    end
  end

  smul_ctrl #(.W(W), .CW(CW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .idx_o    (idx)
  );

  smul_pp_gen #(.W(W), .CW(CW), .P(P)) u_pp (
    .mcand_i  (mcand_q),
    .mplier_i (mplier_q),
    .idx_i    (idx),
    .pp_o     (pp)
  );

  smul_acc #(.P(P)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .en_i     (busy_o),
    .addend_i (pp),
    .acc_o    (product_o)
  );

  logic signed [P-1:0] ref_prod;
  assign ref_prod = $signed(P'($signed(mcand_q))) * $signed(P'($signed(mplier_q)));

  // R4
  product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($signed(product_o) == ref_prod));

  // R6
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mcand_q) && $stable(mplier_q));
endmodule

// File: tb/signed_seq_mult_tb_top.sv
module signed_seq_mult_tb_top;
  localparam int W = 4;
  localparam int P = 2 * W;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         start;
  logic [W-1:0] mc, mp;
  logic         busy, done;
  logic [P-1:0] prod;
  int           checks = 0;
  int           fails  = 0;
  bit           finished = 0;

  always #4 clk = ~clk;

  signed_seq_mult #(.W(W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .mcand_i   (mc),
    .mplier_i  (mp),
    .busy_o    (busy),
    .done_o    (done),
    .product_o (prod)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sprod();
    return int'($signed(prod));
  endfunction

  // One multiplication; optional ignored start with other operands mid-run (R6).
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int exp;
    exp = int'($signed(a)) * int'($signed(b));
    @(negedge clk);
    start = 1'b1; mc = a; mp = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    for (int i = 1; i <= W; i++) begin
      if (poke && i == 1) begin
        start = 1'b1; mc = ~a; mp = b + 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (i < W) begin
        if (done) chk(1'b0, "R3 early done", int'(done), 0);
      end else begin
        chk(done == 1'b1 && busy == 1'b0, "R3 done timing", int'(done), 1);
        chk(sprod() == exp, poke ? "R6 product with ignored start" : "R4 product",
            sprod(), exp);
      end
    end
    mc = a + 1'b1; mp = ~b;
    @(negedge clk);
    chk(done == 1'b0, "R3 done single cycle", int'(done), 0);
    chk(sprod() == exp, "R7 product held", sprod(), exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; start = 1'b0; mc = '0; mp = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && prod == 0, "R1 reset state", int'(prod), 0);
    rst_ni = 1'b1;

    // R4 reference case, R5 most negative operands
    run(4'b1011, 4'b1101, 1'b0);
    chk(prod == 8'b00001111, "R4 -5*-3", int'(prod), 15);
    run(4'b1000, 4'b1000, 1'b0);
    chk(prod == 8'b01000000, "R5 -8*-8", int'(prod), 64);
    run(4'b1000, 4'b0111, 1'b0);
    chk(prod == 8'b11001000, "R5 -8*7", int'(prod), 200);

    // R6 ignored start during a run
    run(4'b0110, 4'b1011, 1'b1);
    run(4'b1000, 4'b1001, 1'b1);

    // R7 hold over idle cycles with input traffic
    begin
      logic [P-1:0] held;
      held = prod;
      repeat (5) begin
        @(negedge clk);
        mc = mc + 1'b1; mp = mp - 1'b1;
      end
      chk(prod == held && !done, "R7 idle hold", int'(prod), int'(held));
    end

    // exhaustive sweep R4/R5
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run(W'(a), W'(b), ((a + b) % 7) == 0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule